// File: doc/BRIEF.md
# Processor Reset Exception Sequencer

This block steers a 32-bit processor core through its reset exception. A reset starts from either the external hardware reset pin or a request pulse from an on-chip module. The reset request has priority over anything else in flight: whatever the sequencer was doing is dropped, and it cannot be resumed. At the edge that starts a sequence, the status word is forced to a fixed value: tracing is off, supervisor mode is on, and the interrupt mask is at its top level. The vector base register is cleared in the same step. The old program counter and status word are not kept anywhere.

The sequencer then reads two long words, one at a time, over a valid/ready memory read interface. The first word becomes the interrupt stack pointer and the second becomes the program counter. Next it raises a one-cycle fetch pulse for the new program counter and hands control to the core. Any error flag on a read response is a double fault. The core then halts, and only the hardware reset pin can wake it. A software-reset command from the running core drives a reset line to the peripherals for a fixed number of cycles and changes no core register.

Back-pressure rules: a request is held with a constant address until `mem_req_ready` is seen high at a clock edge. Only one read is ever outstanding. A response is taken only at an edge where both `mem_rsp_valid` and `mem_rsp_ready` are high. `mem_rsp_ready` is high only while a response is awaited.

Top module: `rst_exception_seq`

## Requirements
- R1: While `hw_rst` is high, `sr_q` is 16'h2700, `vbr_q`, `isp_q` and `pc_q` are zero, and `mem_req_valid`, `mem_rsp_ready`, `fetch_start`, `core_run`, `halted` and `reset_out` are all low. A sequence begins after `hw_rst` is released.
- R2: `int_rst_req` sampled high in any state other than halted aborts the work in progress and restarts the sequence. At that same edge `sr_q` becomes 16'h2700 and `vbr_q` becomes zero. `sr_q` bits: 15 = T1 trace, 14 = T0 trace, 13 = supervisor, 10:8 = interrupt mask. All other bits read zero.
- R3: The first vector read goes to byte address VBR+0 and the second to VBR+4, where VBR is zero. The second request is issued only after the first response has been taken.
- R4: `mem_req_valid` stays high with a stable `mem_req_addr` until it is accepted. `mem_rsp_ready` is high only while a response is awaited and never together with `mem_req_valid`.
- R5: The data of the first good response loads `isp_q`, and the data of the second good response loads `pc_q`.
- R6: In the cycle after the second good response, `fetch_start` is high for one cycle with `pc_q` holding the loaded value. `core_run` is high from the next cycle on.
- R7: A response with `mem_rsp_berr` or `mem_rsp_aerr` high sets `halted`, does not load its data, and stops further requests. `halted` stays set and ignores `int_rst_req` and `sw_reset_cmd`. Only `hw_rst` clears it.
- R8: `sw_reset_cmd` sampled high while `core_run` is high drives `reset_out` high for exactly SWRST_CYCLES cycles, starting the next cycle. It changes no register and leaves `core_run` high. The command is ignored when the core is not running or while a pulse is already active.
- R9: `core_wr_en` writes `core_wr_data` only while `core_run` is high. The target is chosen by `core_wr_sel`: 0 = status word (bits 15, 14, 13 and 10:8 only), 1 = VBR, 2 = ISP, 3 = PC. Writes are ignored during a sequence and while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | External hardware reset, synchronous, active high |
| int_rst_req | input | 1 | Reset request from an on-chip module |
| sw_reset_cmd | input | 1 | Software-reset instruction executed by the core |
| core_wr_en | input | 1 | Core register write strobe |
| core_wr_sel | input | 2 | Register select for the core write |
| core_wr_data | input | DATA_W | Core write data |
| mem_req_valid | output | 1 | Vector read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the vector word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Sequencer awaits a response |
| mem_rsp_data | input | DATA_W | Read response data |
| mem_rsp_berr | input | 1 | Bus error on the response |
| mem_rsp_aerr | input | 1 | Address error on the response |
| sr_q | output | 16 | Status word |
| vbr_q | output | DATA_W | Vector base register |
| isp_q | output | DATA_W | Interrupt stack pointer |
| pc_q | output | DATA_W | Program counter |
| fetch_start | output | 1 | One-cycle start of the first instruction fetch |
| core_run | output | 1 | Core is in normal execution |
| halted | output | 1 | Double fault halt |
| reset_out | output | 1 | Reset line to the peripherals |

## Verification
The bench builds the block with 32-bit addresses and data and with SWRST_CYCLES set to 6. This keeps the whole peripheral pulse short enough to count cycle by cycle, including a second command issued in the middle of the pulse. Every sequence is swept over request latencies of 0 to 2 cycles and response latencies of 0 to 2 cycles. Each sweep point is run with no fault and with a bus or address error on either vector word. Vector values are formed arithmetically from the sweep indices. Separate runs cover an on-chip reset request during a response wait, and requests issued after VBR has been moved away from zero.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int unsigned SR_W       = 16;
  localparam int unsigned SR_T1_BIT  = 15;
  localparam int unsigned SR_T0_BIT  = 14;
  localparam int unsigned SR_S_BIT   = 13;
  localparam int unsigned SR_IPL_LO  = 8;
  localparam int unsigned SR_IPL_W   = 3;

  localparam logic [SR_W-1:0] SR_IPL_FIELD = SR_W'(((1 << SR_IPL_W) - 1) << SR_IPL_LO);
  localparam logic [SR_W-1:0] SR_RESET_VAL = SR_W'(1 << SR_S_BIT) | SR_IPL_FIELD;
  localparam logic [SR_W-1:0] SR_WR_MASK   = SR_W'(1 << SR_T1_BIT) | SR_W'(1 << SR_T0_BIT)
                                           | SR_W'(1 << SR_S_BIT) | SR_IPL_FIELD;

  typedef enum logic [3:0] {
    ST_HOLD  = 4'd0,
    ST_INIT  = 4'd1,
    ST_REQ0  = 4'd2,
    ST_RSP0  = 4'd3,
    ST_REQ1  = 4'd4,
    ST_RSP1  = 4'd5,
    ST_FETCH = 4'd6,
    ST_RUN   = 4'd7,
    ST_HALT  = 4'd8
  } seq_state_e;

  typedef enum logic [1:0] {
    WSEL_SR  = 2'd0,
    WSEL_VBR = 2'd1,
    WSEL_ISP = 2'd2,
    WSEL_PC  = 2'd3
  } wsel_e;

endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              int_rst_req,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_berr,
  input  logic              mem_rsp_aerr,
  input  logic [DATA_W-1:0] vbr_q,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_rsp_ready,
  output logic              start_seq,
  output logic              load_isp,
  output logic              load_pc,
  output logic              fetch_start,
  output logic              core_run,
  output logic              halted
);

  localparam int unsigned WORD_BYTES = DATA_W / 8;

  seq_state_e st_q, st_d;
  logic abort, rsp_take, rsp_err;
  logic [ADDR_W-1:0] base_addr;

  assign abort    = int_rst_req && (st_q != ST_HALT) && (st_q != ST_HOLD);
  assign rsp_take = mem_rsp_valid && mem_rsp_ready;
  assign rsp_err  = mem_rsp_berr || mem_rsp_aerr;

  always_comb begin
    st_d = st_q;
    if (abort) begin
      st_d = ST_INIT;
    end else begin
      case (st_q)
        ST_HOLD:  st_d = ST_INIT;
        ST_INIT:  st_d = ST_REQ0;
        ST_REQ0:  if (mem_req_ready) st_d = ST_RSP0;
        ST_RSP0:  if (rsp_take) st_d = rsp_err ? ST_HALT : ST_REQ1;
        ST_REQ1:  if (mem_req_ready) st_d = ST_RSP1;
        ST_RSP1:  if (rsp_take) st_d = rsp_err ? ST_HALT : ST_FETCH;
        ST_FETCH: st_d = ST_RUN;
        ST_RUN:   st_d = ST_RUN;
        ST_HALT:  st_d = ST_HALT;
        default:  st_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hw_rst) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign base_addr     = vbr_q[ADDR_W-1:0];
  assign mem_req_valid = (st_q == ST_REQ0) || (st_q == ST_REQ1);
  assign mem_req_addr  = base_addr + ((st_q == ST_REQ1) ? ADDR_W'(WORD_BYTES) : '0);
  assign mem_rsp_ready = (st_q == ST_RSP0) || (st_q == ST_RSP1);

  assign start_seq   = (st_q == ST_HOLD) || abort;
  assign load_isp    = (st_q == ST_RSP0) && rsp_take && !rsp_err && !abort;
  assign load_pc     = (st_q == ST_RSP1) && rsp_take && !rsp_err && !abort;
  assign fetch_start = (st_q == ST_FETCH);
  assign core_run    = (st_q == ST_RUN);
  assign halted      = (st_q == ST_HALT);

endmodule

// File: rtl/rst_seq_regs.sv
module rst_seq_regs
  import rst_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              start_seq,
  input  logic              load_isp,
  input  logic              load_pc,
  input  logic [DATA_W-1:0] vec_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SR_W-1:0]   sr_q,
  output logic [DATA_W-1:0] vbr_q,
  output logic [DATA_W-1:0] isp_q,
  output logic [DATA_W-1:0] pc_q
);

  wsel_e sel;
  assign sel = wsel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      sr_q  <= SR_RESET_VAL;
      vbr_q <= '0;
      isp_q <= '0;
      pc_q  <= '0;
    end else if (start_seq) begin
      sr_q  <= SR_RESET_VAL;
      vbr_q <= '0;
    end else begin
      if (load_isp) isp_q <= vec_data;
      if (load_pc)  pc_q  <= vec_data;
      if (wr_en) begin
        case (sel)
          WSEL_SR:  sr_q  <= wr_data[SR_W-1:0] & SR_WR_MASK;
          WSEL_VBR: vbr_q <= wr_data;
          WSEL_ISP: isp_q <= wr_data;
          WSEL_PC:  pc_q  <= wr_data;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rst_seq_swpulse.sv
module rst_seq_swpulse #(
  parameter int unsigned PULSE_CYC = 512
) (
  input  logic clk,
  input  logic hw_rst,
  input  logic trig,
  output logic reset_out
);

  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (hw_rst)                    cnt_q <= '0;
    else if (trig && cnt_q == '0)  cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
  end

  assign reset_out = (cnt_q != '0);

endmodule

// File: rtl/rst_exception_seq.sv
module rst_exception_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SWRST_CYCLES = 512
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              int_rst_req,
  input  logic              sw_reset_cmd,
  input  logic              core_wr_en,
  input  logic [1:0]        core_wr_sel,
  input  logic [DATA_W-1:0] core_wr_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_berr,
  input  logic              mem_rsp_aerr,
  output logic [15:0]       sr_q,
  output logic [DATA_W-1:0] vbr_q,
  output logic [DATA_W-1:0] isp_q,
  output logic [DATA_W-1:0] pc_q,
  output logic              fetch_start,
  output logic              core_run,
  output logic              halted,
  output logic              reset_out
);

  logic start_seq, load_isp, load_pc;
  logic run_wr_en, sw_trig;

  rst_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .hw_rst        (hw_rst),
    .int_rst_req   (int_rst_req),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_berr  (mem_rsp_berr),
    .mem_rsp_aerr  (mem_rsp_aerr),
    .vbr_q         (vbr_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_ready (mem_rsp_ready),
    .start_seq     (start_seq),
    .load_isp      (load_isp),
    .load_pc       (load_pc),
    .fetch_start   (fetch_start),
    .core_run      (core_run),
    .halted        (halted)
  );

  assign run_wr_en = core_wr_en && core_run;

  rst_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .hw_rst    (hw_rst),
    .start_seq (start_seq),
    .load_isp  (load_isp),
    .load_pc   (load_pc),
    .vec_data  (mem_rsp_data),
    .wr_en     (run_wr_en),
    .wr_sel    (core_wr_sel),
    .wr_data   (core_wr_data),
    .sr_q      (sr_q),
    .vbr_q     (vbr_q),
    .isp_q     (isp_q),
    .pc_q      (pc_q)
  );

  assign sw_trig = sw_reset_cmd && core_run;

  rst_seq_swpulse #(.PULSE_CYC(SWRST_CYCLES)) u_swp (
    .clk       (clk),
    .hw_rst    (hw_rst),
    .trig      (sw_trig),
    .reset_out (reset_out)
  );

endmodule

// File: rtl/rst_exception_seq_chk.sv
module rst_exception_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              hw_rst,
  input logic              int_rst_req,
  input logic              core_wr_en,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_ready,
  input logic [15:0]       sr_q,
  input logic [DATA_W-1:0] vbr_q,
  input logic [DATA_W-1:0] isp_q,
  input logic [DATA_W-1:0] pc_q,
  input logic              fetch_start,
  input logic              core_run,
  input logic              halted,
  input logic              reset_out
);

  p_init_values_r2: assert property (@(posedge clk) disable iff (hw_rst)
    int_rst_req && !halted |=> (sr_q == 16'h2700) && (vbr_q == '0));

  p_vec_addr_r3: assert property (@(posedge clk) disable iff (hw_rst)
    mem_req_valid |-> (mem_req_addr == '0) || (mem_req_addr == ADDR_W'(4)));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (hw_rst)
    mem_req_valid && !mem_req_ready && !int_rst_req |=> mem_req_valid && $stable(mem_req_addr));

  p_one_side_r4: assert property (@(posedge clk) disable iff (hw_rst)
    !(mem_req_valid && mem_rsp_ready));

  p_fetch_then_run_r6: assert property (@(posedge clk) disable iff (hw_rst)
    fetch_start && !int_rst_req |=> core_run && !fetch_start);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (hw_rst)
    halted |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (hw_rst)
    halted |-> !mem_req_valid && !mem_rsp_ready && !core_run && !reset_out);

  p_swrst_keeps_r8: assert property (@(posedge clk) disable iff (hw_rst)
    reset_out && core_run && !int_rst_req && !core_wr_en |=>
      $stable(sr_q) && $stable(vbr_q) && $stable(isp_q) && $stable(pc_q) && core_run);

endmodule

bind rst_exception_seq rst_exception_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .hw_rst        (hw_rst),
  .int_rst_req   (int_rst_req),
  .core_wr_en    (core_wr_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .sr_q          (sr_q),
  .vbr_q         (vbr_q),
  .isp_q         (isp_q),
  .pc_q          (pc_q),
  .fetch_start   (fetch_start),
  .core_run      (core_run),
  .halted        (halted),
  .reset_out     (reset_out)
);

// File: tb/sim_rst_exception_seq.sv
`timescale 1ns/1ps
module sim_rst_exception_seq;

  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned NPULSE = 6;

  logic clk = 1'b0;
  logic hw_rst = 1'b1, int_rst_req = 1'b0, sw_reset_cmd = 1'b0;
  logic core_wr_en = 1'b0;
  logic [1:0] core_wr_sel = '0;
  logic [DW-1:0] core_wr_data = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0;
  logic mem_rsp_berr = 1'b0, mem_rsp_aerr = 1'b0;
  logic [15:0] sr_q;
  logic [DW-1:0] vbr_q, isp_q, pc_q;
  logic fetch_start, core_run, halted, reset_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rst_exception_seq #(.ADDR_W(AW), .DATA_W(DW), .SWRST_CYCLES(NPULSE)) u0 (
    .clk(clk), .hw_rst(hw_rst), .int_rst_req(int_rst_req), .sw_reset_cmd(sw_reset_cmd),
    .core_wr_en(core_wr_en), .core_wr_sel(core_wr_sel), .core_wr_data(core_wr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_berr(mem_rsp_berr), .mem_rsp_aerr(mem_rsp_aerr),
    .sr_q(sr_q), .vbr_q(vbr_q), .isp_q(isp_q), .pc_q(pc_q),
    .fetch_start(fetch_start), .core_run(core_run), .halted(halted), .reset_out(reset_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_hw_reset();
    hw_rst = 1'b1;
    repeat (3) tick();
    chk(sr_q == 16'h2700, "R1 sr", sr_q, 16'h2700);
    chk(vbr_q == 0 && isp_q == 0 && pc_q == 0, "R1 regs", {vbr_q, pc_q}, 0);
    chk({mem_req_valid, mem_rsp_ready, fetch_start, core_run, halted, reset_out} == 6'b0,
        "R1 ctl", {mem_req_valid, mem_rsp_ready, fetch_start, core_run, halted, reset_out}, 0);
    hw_rst = 1'b0;
  endtask

  // err: 0 none, 1 bus error, 2 address error
  task automatic serve(input int idx, input logic [DW-1:0] data, input int rl, input int sl,
                       input int err);
    int guard = 0;
    logic [AW-1:0] a0;
    while (!mem_req_valid && guard < 50) begin tick(); guard++; end
    chk(mem_req_valid, "R3 request seen", mem_req_valid, 1);
    chk(mem_req_addr == AW'(idx * 4), "R3 vector address", mem_req_addr, idx * 4);
    chk(!mem_rsp_ready, "R4 rsp_ready idle", mem_rsp_ready, 0);
    a0 = mem_req_addr;
    for (int k = 0; k < rl; k++) begin
      tick();
      chk(mem_req_valid && mem_req_addr == a0, "R4 request held", mem_req_addr, a0);
    end
    mem_req_ready = 1'b1;
    tick();
    mem_req_ready = 1'b0;
    chk(mem_rsp_ready && !mem_req_valid, "R4 awaiting response", {mem_rsp_ready, mem_req_valid}, 2'b10);
    for (int k = 0; k < sl; k++) tick();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    mem_rsp_berr  = (err == 1);
    mem_rsp_aerr  = (err == 2);
    tick();
    mem_rsp_valid = 1'b0;
    mem_rsp_berr  = 1'b0;
    mem_rsp_aerr  = 1'b0;
    mem_rsp_data  = '0;
  endtask

  task automatic check_halt(input logic [DW-1:0] exp_isp);
    chk(halted && !core_run, "R7 halted", halted, 1);
    chk(isp_q == exp_isp && pc_q == 0, "R7 data not loaded", {isp_q, pc_q}, {exp_isp, 32'h0});
    sw_reset_cmd = 1'b1; tick(); sw_reset_cmd = 1'b0;
    int_rst_req  = 1'b1; tick(); int_rst_req  = 1'b0;
    repeat (3) tick();
    chk(halted && !mem_req_valid && !reset_out, "R7 halt sticky",
        {halted, mem_req_valid, reset_out}, 3'b100);
  endtask

  // ep: 0 none, 1/2 bus/address error on word 0, 3/4 on word 1
  task automatic run_boot(input logic [DW-1:0] isp_v, input logic [DW-1:0] pc_v,
                          input int rl, input int sl, input int ep);
    serve(0, isp_v, rl, sl, (ep <= 2) ? ep : 0);
    if (ep == 1 || ep == 2) begin
      check_halt(0);
      return;
    end
    chk(isp_q == isp_v, "R5 isp loaded", isp_q, isp_v);
    serve(1, pc_v, rl, sl, (ep >= 3) ? ep - 2 : 0);
    if (ep >= 3) begin
      check_halt(isp_v);
      return;
    end
    chk(fetch_start && pc_q == pc_v && !core_run, "R6 fetch pulse", {fetch_start, pc_q}, {1'b1, pc_v});
    tick();
    chk(!fetch_start && core_run, "R6 running", {fetch_start, core_run}, 2'b01);
    chk(sr_q == 16'h2700 && vbr_q == 0, "R2 sr after boot", sr_q, 16'h2700);
  endtask

  task automatic core_write(input logic [1:0] sel, input logic [DW-1:0] d);
    core_wr_en = 1'b1; core_wr_sel = sel; core_wr_data = d;
    tick();
    core_wr_en = 1'b0;
  endtask

  initial begin
    int n;
    tick();
    // Sweep over handshake latencies and fault placement
    for (int rl = 0; rl < 3; rl++)
      for (int sl = 0; sl < 3; sl++)
        for (int ep = 0; ep < 5; ep++) begin
          do_hw_reset();
          run_boot(32'h0001_0000 + DW'(rl * 256 + sl * 16 + ep),
                   32'h0000_4000 + DW'(ep * 4096 + rl * 64 + sl * 8), rl, sl, ep);
        end

    // R9: core writes while running
    do_hw_reset();
    run_boot(32'h0000_F000, 32'h0000_0400, 0, 0, 0);
    core_write(2'd0, 32'hFFFF_FFFF);
    chk(sr_q == 16'hE700, "R9 sr mask", sr_q, 16'hE700);
    core_write(2'd1, 32'h0000_1000);
    core_write(2'd2, 32'h1234_5678);
    core_write(2'd3, 32'h0000_8000);
    chk(vbr_q == 32'h1000 && isp_q == 32'h1234_5678 && pc_q == 32'h8000, "R9 writes",
        {vbr_q, pc_q}, {32'h1000, 32'h8000});

    // R8: software reset pulse, second command mid-pulse ignored
    sw_reset_cmd = 1'b1; tick(); sw_reset_cmd = 1'b0;
    n = 0;
    while (reset_out && n < 100) begin
      n++;
      sw_reset_cmd = (n == 2);
      tick();
    end
    sw_reset_cmd = 1'b0;
    chk(n == NPULSE, "R8 pulse length", n, NPULSE);
    chk(sr_q == 16'hE700 && vbr_q == 32'h1000 && isp_q == 32'h1234_5678 && pc_q == 32'h8000 && core_run,
        "R8 registers kept", {sr_q, pc_q}, {16'hE700, 32'h8000});

    // R2: on-chip reset request forces SR/VBR at once; R8/R9 ignored during sequence
    int_rst_req = 1'b1; tick(); int_rst_req = 1'b0;
    chk(sr_q == 16'h2700 && vbr_q == 0 && !core_run, "R2 forced at request", {sr_q, vbr_q}, {16'h2700, 32'h0});
    sw_reset_cmd = 1'b1; core_wr_en = 1'b1; core_wr_sel = 2'd2; core_wr_data = 32'hDEAD_0000;
    tick();
    sw_reset_cmd = 1'b0; core_wr_en = 1'b0;
    tick();
    chk(!reset_out, "R8 ignored in sequence", reset_out, 0);
    chk(isp_q == 32'h1234_5678, "R9 ignored in sequence", isp_q, 32'h1234_5678);
    run_boot(32'hA0A0_0000, 32'h0000_0200, 1, 1, 0);

    // R2: abort while waiting for the second response
    int_rst_req = 1'b1; tick(); int_rst_req = 1'b0;
    serve(0, 32'h5555_0000, 0, 0, 0);
    while (!mem_req_valid) tick();
    mem_req_ready = 1'b1; tick(); mem_req_ready = 1'b0;
    int_rst_req = 1'b1; tick(); int_rst_req = 1'b0;
    chk(!mem_rsp_ready && !mem_req_valid, "R2 abort drops wait", {mem_rsp_ready, mem_req_valid}, 0);
    run_boot(32'h6666_0000, 32'h0000_0300, 2, 0, 0);

    // R7: only hardware reset leaves halt
    do_hw_reset();
    run_boot(32'h7777_0000, 32'h0, 0, 1, 3);
    do_hw_reset();
    chk(!halted, "R7 cleared by hw reset", halted, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule